// File: doc/BRIEF.md
# Processor / Hardware Cross-Call Sequencer

This block arbitrates function calls that cross between a host processor and a set of hardware function units, in either direction. Software starts a unit by writing its identifier to a command register. The unit is enabled until it pulses its done line. The block then records a per-unit finish flag and raises a level interrupt.

A running unit can call a software routine. It raises a request together with an 8-bit routine identifier. The block suspends the unit by dropping its enable, interrupts the processor and exposes the routine identifier and the caller. A write to a completion register resumes the caller. A running unit can also call another idle unit directly. The caller is suspended and the target is enabled in a single cycle. When the target finishes, the caller is re-enabled and software sees nothing.

Top module: `xcall_ctrl`

## Requirements
- R1: After reset all unit enables are low, the interrupt is low and every register reads zero.
- R2: A write to address 0 with a unit number in bits [3:0] below 4, naming an idle unit, raises that unit's enable on the next cycle.
- R3: When a unit started by software pulses done, its enable falls on the next cycle, status bit 8+unit is set and the interrupt rises.
- R4: The interrupt is high exactly while any status bit is set. Bit 0 is error, bit 1 is a dispatched software call, and bits 8 to 11 are per-unit finish flags. Writing ones to address 2 clears those bits.
- R5: A command write naming a unit number of 4 or more, or a unit that is not idle, sets status bit 0 and changes no enable.
- R6: A software request from a running unit drops its enable on the next cycle. Two cycles after the request, status bit 1 is set and address 3 reads the routine identifier in bits [7:0] and the caller in bits [17:16].
- R7: A write to address 1 while a software call is being served re-enables the caller on the next cycle.
- R8: Only one software call is served at a time. Units waiting for service are dispatched lowest unit number first.
- R9: A write to address 1 with no software call being served sets status bit 0.
- R10: A unit-to-unit call suspends the caller and enables the target on the next cycle. When the target pulses done, the caller is re-enabled on the next cycle and no status bit is set.
- R11: A unit-to-unit call naming the caller itself sets status bit 0 and changes no enable.
- R12: A unit-to-unit call to a busy target waits, with the request held, and is granted on the cycle after the target becomes idle.
- R13: Read data for an address appears on the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after address |
| irq_o | output | 1 | Level interrupt to the processor |
| unit_en_o | output | 4 | Enable per unit |
| unit_done_i | input | 4 | Completion pulse per unit |
| unit_swreq_i | input | 4 | Software-call request per unit |
| unit_swid_i | input | 32 | Routine identifier per unit, 8 bits each |
| unit_hwreq_i | input | 4 | Unit-to-unit call request per unit |
| unit_hwtgt_i | input | 8 | Target unit number per unit, 2 bits each |

## Verification
Command, completion and done inputs affect enables, status and the interrupt one clock edge later. A software request reaches the status and identifier registers two edges later, because the waiting unit must first be registered before the arbiter dispatches it. A register read is due one edge after its address. Each check is queued with the cycle in which its result is due, and the monitor compares it in exactly that cycle. Waits between steps are chosen so that every read samples only settled state.

// File: rtl/xcall_pkg.sv
package xcall_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RUN  = 2'd1,
    SLOT_WSW  = 2'd2,
    SLOT_WHW  = 2'd3
  } slot_st_e;

  localparam int          REG_AW     = 2;
  localparam int          REG_DW     = 32;
  localparam logic [1:0]  REG_CALL   = 2'd0;
  localparam logic [1:0]  REG_DONE   = 2'd1;
  localparam logic [1:0]  REG_STAT   = 2'd2;
  localparam logic [1:0]  REG_SWINFO = 2'd3;
  localparam int          ST_ERR     = 0;
  localparam int          ST_SW      = 1;
  localparam int          ST_FIN     = 8;
  localparam int          INFO_CALLER = 16;
endpackage

// File: rtl/xcall_arb.sv
module xcall_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  assign vld_o = |req_i;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xcall_slot.sv
module xcall_slot
  import xcall_pkg::*;
#(
  parameter int SWID_W = 8,
  parameter int HWID_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_sw_i,
  input  logic              start_hw_i,
  input  logic [HWID_W-1:0] ret_id_i,
  input  logic              resume_i,
  input  logic              done_i,
  input  logic              swreq_i,
  input  logic [SWID_W-1:0] swid_i,
  input  logic              hw_go_i,
  output logic              run_o,
  output logic              idle_o,
  output logic              wsw_o,
  output logic [SWID_W-1:0] swid_o,
  output logic [HWID_W-1:0] ret_id_o,
  output logic              fin_sw_o,
  output logic              fin_hw_o
);
  slot_st_e          st_q;
  logic              ret_hw_q;
  logic [HWID_W-1:0] ret_id_q;
  logic [SWID_W-1:0] swid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SLOT_IDLE;
      ret_hw_q <= 1'b0;
      ret_id_q <= '0;
      swid_q   <= '0;
    end else begin
      unique case (st_q)
        SLOT_IDLE: begin
          if (start_sw_i) begin
            st_q     <= SLOT_RUN;
            ret_hw_q <= 1'b0;
          end else if (start_hw_i) begin
            st_q     <= SLOT_RUN;
            ret_hw_q <= 1'b1;
            ret_id_q <= ret_id_i;
          end
        end
        SLOT_RUN: begin
          if (done_i) begin
            st_q <= SLOT_IDLE;
          end else if (swreq_i) begin
            st_q   <= SLOT_WSW;
            swid_q <= swid_i;
          end else if (hw_go_i) begin
            st_q <= SLOT_WHW;
          end
        end
        SLOT_WSW, SLOT_WHW: begin
          if (resume_i) st_q <= SLOT_RUN;
        end
        default: st_q <= SLOT_IDLE;
      endcase
    end
  end

  assign run_o    = (st_q == SLOT_RUN);
  assign idle_o   = (st_q == SLOT_IDLE);
  assign wsw_o    = (st_q == SLOT_WSW);
  assign swid_o   = swid_q;
  assign ret_id_o = ret_id_q;
  assign fin_sw_o = run_o && done_i && !ret_hw_q;
  assign fin_hw_o = run_o && done_i && ret_hw_q;

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && done_i |=> idle_o);
  // R6
  swreq_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !done_i && swreq_i |=> wsw_o && swid_o == $past(swid_i));
  // R7
  resume_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o && !idle_o && resume_i |=> run_o);
endmodule

// File: rtl/xcall_regs.sv
module xcall_regs
  import xcall_pkg::*;
#(
  parameter int N      = 4,
  parameter int SWID_W = 8,
  parameter int HWID_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [REG_AW-1:0]        addr_i,
  input  logic [REG_DW-1:0]        wdata_i,
  input  logic                     err_set_i,
  input  logic                     sw_set_i,
  input  logic [HWID_W+SWID_W-1:0] swinfo_i,
  input  logic [N-1:0]             fin_set_i,
  output logic [REG_DW-1:0]        rdata_o,
  output logic                     irq_o,
  output logic                     err_o
);
  logic                     err_q, sw_q;
  logic [N-1:0]             fin_q;
  logic [HWID_W+SWID_W-1:0] info_q;
  logic [REG_DW-1:0]        rdata_q, stat_w, info_w;
  logic                     stat_clr;

  assign stat_clr = wr_i && (addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      sw_q   <= 1'b0;
      fin_q  <= '0;
      info_q <= '0;
    end else begin
      err_q <= err_set_i || (err_q && !(stat_clr && wdata_i[ST_ERR]));
      sw_q  <= sw_set_i  || (sw_q  && !(stat_clr && wdata_i[ST_SW]));
      fin_q <= fin_set_i | (fin_q & ~(stat_clr ? wdata_i[ST_FIN +: N] : '0));
      if (sw_set_i) info_q <= swinfo_i;
    end
  end

  always_comb begin
    stat_w             = '0;
    stat_w[ST_ERR]     = err_q;
    stat_w[ST_SW]      = sw_q;
    stat_w[ST_FIN +: N] = fin_q;
    info_w             = '0;
    info_w[SWID_W-1:0] = info_q[SWID_W-1:0];
    info_w[INFO_CALLER +: HWID_W] = info_q[HWID_W+SWID_W-1:SWID_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      unique case (addr_i)
        REG_STAT:   rdata_q <= stat_w;
        REG_SWINFO: rdata_q <= info_w;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = err_q || sw_q || (|fin_q);
  assign err_o   = err_q;

  // R4
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(stat_clr));
endmodule

// File: rtl/xcall_ctrl.sv
module xcall_ctrl
  import xcall_pkg::*;
#(
  parameter  int NUM_UNITS = 4,
  parameter  int SWID_W    = 8,
  parameter  int CALL_ID_W = 4,
  localparam int HWID_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [REG_AW-1:0]             reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [REG_DW-1:0]             reg_wdata_i,
  output logic [REG_DW-1:0]             reg_rdata_o,
  output logic                          irq_o,
  output logic [NUM_UNITS-1:0]          unit_en_o,
  input  logic [NUM_UNITS-1:0]          unit_done_i,
  input  logic [NUM_UNITS-1:0]          unit_swreq_i,
  input  logic [NUM_UNITS*SWID_W-1:0]   unit_swid_i,
  input  logic [NUM_UNITS-1:0]          unit_hwreq_i,
  input  logic [NUM_UNITS*HWID_W-1:0]   unit_hwtgt_i
);
  logic [NUM_UNITS-1:0] run, idle, wsw, fin_sw, fin_hw;
  logic [NUM_UNITS-1:0] start_sw, start_hw, resume, hw_go;
  logic [NUM_UNITS-1:0] hw_vld, hw_bad, hw_ok;
  logic [SWID_W-1:0]    swid_held [NUM_UNITS];
  logic [HWID_W-1:0]    ret_id    [NUM_UNITS];
  logic [HWID_W-1:0]    tgt       [NUM_UNITS];

  logic [CALL_ID_W-1:0] call_id;
  logic [HWID_W-1:0]    call_idx;
  logic                 wr_call, wr_done, call_in_rng, call_ok;
  logic                 active_q;
  logic [HWID_W-1:0]    active_id_q;
  logic                 sw_gnt_vld, hw_gnt_vld, err_set, err;
  logic [HWID_W-1:0]    sw_gnt_idx, hw_gnt_idx, hw_gnt_tgt;

  assign wr_call     = reg_wr_i && (reg_addr_i == REG_CALL);
  assign wr_done     = reg_wr_i && (reg_addr_i == REG_DONE);
  assign call_id     = reg_wdata_i[CALL_ID_W-1:0];
  assign call_idx    = call_id[HWID_W-1:0];
  assign call_in_rng = 32'(call_id) < NUM_UNITS;
  assign call_ok     = wr_call && call_in_rng && idle[call_idx];

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    assign tgt[i]      = unit_hwtgt_i[i*HWID_W +: HWID_W];
    assign start_sw[i] = call_ok && (call_idx == HWID_W'(i));
    assign hw_vld[i]   = run[i] && !unit_done_i[i] && !unit_swreq_i[i] && unit_hwreq_i[i];
    assign hw_bad[i]   = (32'(tgt[i]) >= NUM_UNITS) || (tgt[i] == HWID_W'(i));
    assign hw_ok[i]    = hw_vld[i] && !hw_bad[i] && idle[tgt[i]] && !start_sw[tgt[i]];
    assign start_hw[i] = hw_gnt_vld && (hw_gnt_tgt == HWID_W'(i));
    assign hw_go[i]    = hw_gnt_vld && (hw_gnt_idx == HWID_W'(i));

    xcall_slot #(.SWID_W(SWID_W), .HWID_W(HWID_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_sw_i (start_sw[i]),
      .start_hw_i (start_hw[i]),
      .ret_id_i   (hw_gnt_idx),
      .resume_i   (resume[i]),
      .done_i     (unit_done_i[i]),
      .swreq_i    (unit_swreq_i[i]),
      .swid_i     (unit_swid_i[i*SWID_W +: SWID_W]),
      .hw_go_i    (hw_go[i]),
      .run_o      (run[i]),
      .idle_o     (idle[i]),
      .wsw_o      (wsw[i]),
      .swid_o     (swid_held[i]),
      .ret_id_o   (ret_id[i]),
      .fin_sw_o   (fin_sw[i]),
      .fin_hw_o   (fin_hw[i])
    );
  end

  // software dispatch: one call in service
  xcall_arb #(.N(NUM_UNITS), .IDX_W(HWID_W)) u_sw_arb (
    .req_i (wsw & {NUM_UNITS{!active_q}}),
    .vld_o (sw_gnt_vld),
    .idx_o (sw_gnt_idx)
  );

  // unit-to-unit: one grant per cycle
  xcall_arb #(.N(NUM_UNITS), .IDX_W(HWID_W)) u_hw_arb (
    .req_i (hw_ok),
    .vld_o (hw_gnt_vld),
    .idx_o (hw_gnt_idx)
  );
  assign hw_gnt_tgt = tgt[hw_gnt_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      active_id_q <= '0;
    end else if (sw_gnt_vld) begin
      active_q    <= 1'b1;
      active_id_q <= sw_gnt_idx;
    end else if (wr_done) begin
      active_q    <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      resume[i] = wr_done && active_q && (active_id_q == HWID_W'(i));
      for (int j = 0; j < NUM_UNITS; j++) begin
        if (fin_hw[j] && (ret_id[j] == HWID_W'(i))) resume[i] = 1'b1;
      end
    end
  end

  assign err_set = (wr_call && !call_ok) || (wr_done && !active_q) || (|(hw_vld & hw_bad));

  xcall_regs #(.N(NUM_UNITS), .SWID_W(SWID_W), .HWID_W(HWID_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .err_set_i (err_set),
    .sw_set_i  (sw_gnt_vld),
    .swinfo_i  ({sw_gnt_idx, swid_held[sw_gnt_idx]}),
    .fin_set_i (fin_sw),
    .rdata_o   (reg_rdata_o),
    .irq_o     (irq_o),
    .err_o     (err)
  );

  assign unit_en_o = run;

  // R2
  call_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_ok |=> unit_en_o[$past(call_idx)]);
  // R10
  hw_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_gnt_vld |=> unit_en_o[$past(hw_gnt_tgt)] && !unit_en_o[$past(hw_gnt_idx)]);
  // R8
  sw_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !wr_done |=> active_q && $stable(active_id_q));
  // R9
  done_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && !active_q |=> err);
endmodule

// File: tb/xcall_ctrl_bench.sv
`timescale 1ns/1ps
module xcall_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  en;
  logic [3:0]  done = '0, swreq = '0, hwreq = '0;
  logic [31:0] swid = '0;
  logic [7:0]  hwtgt = '0;

  int cyc = 0, n_chk = 0, n_fail = 0;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xcall_ctrl u_xcall_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .unit_en_o(en),
    .unit_done_i(done), .unit_swreq_i(swreq), .unit_swid_i(swid),
    .unit_hwreq_i(hwreq), .unit_hwtgt_i(hwtgt)
  );

  // monitor: compare each item in the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = {28'd0, en};
        default: act = {31'd0, irq};
      endcase
      n_chk++;
      if (it.due != cyc || act !== it.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h (cycle %0d due %0d)", it.req, act, it.val, cyc, it.due);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic push(int sel, logic [31:0] val, string req);
    sb.push_back('{cyc + 1, sel, val, req});
  endtask
  task automatic chk_en(logic [3:0] v, string req);  push(1, {28'd0, v}, req); endtask
  task automatic chk_irq(logic v, string req);       push(2, {31'd0, v}, req); endtask
  task automatic rd(logic [1:0] a, logic [31:0] v, string req);
    addr = a; push(0, v, req); step();
  endtask
  task automatic wreg(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1; step(); wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk_en(4'b0000, "R1"); chk_irq(1'b0, "R1"); rd(2'd2, 32'h0, "R1");
    rd(2'd3, 32'h0, "R1");
    // R2 software start
    chk_en(4'b0100, "R2"); wreg(2'd0, 32'd2);
    // R3 finish
    done = 4'b0100; chk_en(4'b0000, "R3"); chk_irq(1'b1, "R3"); step(); done = '0;
    rd(2'd2, 32'h400, "R3"); step();
    // R4 clear
    chk_irq(1'b0, "R4"); wreg(2'd2, 32'h400);
    rd(2'd2, 32'h0, "R4"); step();
    // R5 out of range and busy
    chk_en(4'b0000, "R5"); wreg(2'd0, 32'd5);
    rd(2'd2, 32'h1, "R5"); chk_irq(1'b0, "R4"); wreg(2'd2, 32'h1);
    wreg(2'd0, 32'd1);
    chk_en(4'b0010, "R5"); wreg(2'd0, 32'd1);
    rd(2'd2, 32'h1, "R5"); wreg(2'd2, 32'h1);
    // R6 software call from unit 1
    swreq = 4'b0010; swid = 32'h0000_A500; chk_en(4'b0000, "R6"); step();
    swreq = '0; chk_irq(1'b1, "R6"); step();
    rd(2'd3, 32'h0001_00A5, "R6 R13"); rd(2'd2, 32'h2, "R6"); step();
    wreg(2'd2, 32'h2);
    // R7 resume
    chk_en(4'b0010, "R7"); chk_irq(1'b0, "R7"); wreg(2'd1, 32'h0);
    done = 4'b0010; step(); done = '0; wreg(2'd2, 32'h200);
    // R8 priority among waiting callers
    wreg(2'd0, 32'd0); wreg(2'd0, 32'd1); wreg(2'd0, 32'd3);
    swreq = 4'b1011; swid = 32'h1300_1110; chk_en(4'b0000, "R8"); step();
    swreq = '0; step(); step();
    rd(2'd3, 32'h0000_0010, "R8"); wreg(2'd2, 32'h2);
    chk_en(4'b0001, "R8"); wreg(2'd1, 32'h0); step(); step();
    rd(2'd3, 32'h0001_0011, "R8"); wreg(2'd2, 32'h2);
    chk_en(4'b0011, "R8"); wreg(2'd1, 32'h0); step(); step();
    rd(2'd3, 32'h0003_0013, "R8"); wreg(2'd2, 32'h2);
    chk_en(4'b1011, "R8"); wreg(2'd1, 32'h0); step();
    rd(2'd2, 32'h0, "R8"); step();
    done = 4'b1011; step(); done = '0; wreg(2'd2, 32'hB00);
    // R9 stray completion
    wreg(2'd1, 32'h0); rd(2'd2, 32'h1, "R9"); wreg(2'd2, 32'h1);
    // R10 unit-to-unit call 0 -> 2
    wreg(2'd0, 32'd0);
    hwreq = 4'b0001; hwtgt = 8'h02; chk_en(4'b0100, "R10"); step(); hwreq = '0;
    done = 4'b0100; chk_en(4'b0001, "R10"); step(); done = '0;
    rd(2'd2, 32'h0, "R10"); chk_irq(1'b0, "R10"); step();
    // R11 self call
    hwreq = 4'b0001; hwtgt = 8'h00; chk_en(4'b0001, "R11"); step(); hwreq = '0;
    rd(2'd2, 32'h1, "R11"); wreg(2'd2, 32'h1);
    // R12 busy target
    wreg(2'd0, 32'd1);
    hwreq = 4'b0001; hwtgt = 8'h01; chk_en(4'b0011, "R12"); step();
    chk_en(4'b0011, "R12"); step();
    done = 4'b0010; chk_en(4'b0001, "R12"); step(); done = '0;
    chk_en(4'b0010, "R12"); step(); hwreq = '0;
    done = 4'b0010; chk_en(4'b0001, "R12"); step(); done = '0;
    rd(2'd2, 32'h200, "R12"); step(); wreg(2'd2, 32'h200);
    done = 4'b0001; step(); done = '0;
    rd(2'd2, 32'h100, "R3"); step(); wreg(2'd2, 32'h100);
    chk_irq(1'b0, "R4"); step();
    repeat (3) step();
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule